// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break Lockout

This block receives asynchronous serial characters. The line is sampled sixteen times per bit on a baud tick. Each bit is decided by a majority vote over three samples around mid-bit. Good characters go into a sixteen-entry receive queue, which software drains through a read strobe. Parity and framing problems set flags that stay set until cleared. Characters keep arriving while those flags are up.

A break is a line that stays low well past the point where a stop bit was due. It is handled differently from other errors. It sets its own flag, writes nothing into the queue and locks the receiver. From then on no character is taken until software pulses the soft reset or the system reset is applied. A soft reset also empties the queue, clears every flag and disables the queue. Software must enable the queue again afterwards.

Top module: `uart_rx_break_top`

## Requirements
- R1: After system reset, the level is 0, the queue-enable output is 0, and the perr, ferr, brk, ovf and irq outputs are all 0.
- R2: Frame timing and ordering:
  - One bit lasts 16 ticks. A low sample on a tick while idle starts a frame, and the start is kept only if the line is still low at sample 8.
  - Each bit value is the majority of samples 7, 8 and 9. Data bits arrive LSB first.
  - Stored characters are read oldest first: rd_data_o shows the oldest entry, and a pulse on rd_en_i removes it.
- R3: When parity is enabled, one parity bit follows the data bits, and the data plus parity must hold an even number of ones. A mismatch sets perr_o, which stays set, and the character is still stored.
- R4: Framing errors:
  - A low stop bit followed by a high sample within 153 ticks sets ferr_o, which stays set.
  - The character is still stored, and brk_o stays 0.
  - Later good characters are stored normally.
- R5: If the line stays low for 154 ticks after a failed stop sample, brk_o is set and no character is written for that frame.
- R6: While brk_o is 1, no character is accepted and the level stays unchanged. Later valid frames do not clear brk_o; only a soft reset or a system reset does.
- R7: irq_o equals irq_en_i AND (level non-zero OR brk_o).
- R8: While sleep_i is 1, completed characters are discarded and perr/ferr are not updated. A break is still detected and still locks the receiver.
- R9: A character that arrives while the level is 16 is dropped and sets ovf_o, which stays set. The first 16 characters are kept.
- R10: While srst_i is 1, the following hold:
  - the receiver is held idle;
  - the queue is emptied;
  - perr, ferr, brk and ovf are cleared;
  - the queue-enable is cleared.
- R11: A pulse on fifo_en_set_i sets the queue-enable. Characters that complete while it is 0 are discarded and do not set ovf.
- R12: While rx_en_i is 0 (and no break is held), the line is ignored and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Oversample strobe, 16 per bit |
| rx_en_i | input | 1 | Receiver enable |
| par_en_i | input | 1 | Even parity bit expected |
| sleep_i | input | 1 | Discard characters, keep break detection |
| irq_en_i | input | 1 | Receive/break interrupt enable |
| srst_i | input | 1 | Soft reset, active high |
| fifo_en_set_i | input | 1 | Pulse to enable the receive queue |
| rd_en_i | input | 1 | Pop the oldest entry |
| rd_data_o | output | 8 | Oldest queued character |
| level_o | output | 5 | Number of queued characters |
| fifo_en_o | output | 1 | Queue enable state |
| perr_o | output | 1 | Sticky parity error |
| ferr_o | output | 1 | Sticky framing error |
| brk_o | output | 1 | Sticky break, receiver locked |
| ovf_o | output | 1 | Sticky overflow |
| irq_o | output | 1 | Interrupt request |

## Verification
A bit counter that drifts shows up as wrong bytes at rd_data_o in the frame where it drifts. A broken break count shows up within one frame: a long low run reports framing instead of break, or a short run locks the receiver. A lock that leaks is seen as a level that rises after brk_o has gone high. The flags and level are compared with a behavioural model two bit times after every frame, so an error surfaces no later than the frame after its cause.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_HUNT,
        S_LOCK
    } rx_state_e;

endpackage

// File: rtl/uart_rxb_frame.sv
module uart_rxb_frame
    import uart_rxb_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OSR       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 en_i,
    input  logic                 tick_i,
    input  logic                 rx_i,
    input  logic                 par_en_i,
    output logic                 evt_valid_o,
    output logic [DATA_BITS-1:0] evt_data_o,
    output logic                 evt_perr_o,
    output logic                 evt_ferr_o,
    output logic                 evt_brk_o,
    output logic                 locked_o
);

    localparam int CW        = $clog2(OSR);
    localparam int MID       = OSR / 2;
    localparam int BRK_TICKS = (OSR * 77) / 8;
    localparam int BW        = $clog2(BRK_TICKS + 1);
    localparam int IW        = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    typedef struct packed {
        rx_state_e            state;
        logic [CW-1:0]        tcnt;
        logic [IW-1:0]        bidx;
        logic [DATA_BITS-1:0] shreg;
        logic                 par;
        logic                 perr;
        logic [1:0]           vote;
        logic [BW-1:0]        bcnt;
        logic                 evt_valid;
        logic                 evt_ferr;
        logic                 evt_brk;
    } frm_t;

    localparam frm_t FRM_RST = '{
        state: S_IDLE, tcnt: '0, bidx: '0, shreg: '0, par: 1'b0, perr: 1'b0,
        vote: '0, bcnt: '0, evt_valid: 1'b0, evt_ferr: 1'b0, evt_brk: 1'b0
    };

    frm_t          frm_d, frm_q;
    logic [CW-1:0] nt;
    logic          maj;
    logic          at_vote, at_decide, at_end;

    assign nt        = CW'(frm_q.tcnt + 1'b1);
    assign maj       = (frm_q.vote[1] & frm_q.vote[0]) | (frm_q.vote[1] & rx_i) | (frm_q.vote[0] & rx_i);
    assign at_vote   = (nt == CW'(MID - 1)) || (nt == CW'(MID));
    assign at_decide = (nt == CW'(MID + 1));
    assign at_end    = (nt == CW'(OSR - 1));

    always_comb begin
        frm_d           = frm_q;
        frm_d.evt_valid = 1'b0;
        frm_d.evt_ferr  = 1'b0;
        frm_d.evt_brk   = 1'b0;
        if (clr_i) begin
            frm_d = FRM_RST;
        end else if (!en_i && frm_q.state != S_LOCK) begin
            frm_d.state = S_IDLE;
        end else if (tick_i) begin
            if (frm_q.state inside {S_START, S_DATA, S_PAR, S_STOP}) begin
                frm_d.tcnt = nt;
                if (at_vote) frm_d.vote = {frm_q.vote[0], rx_i};
            end
            unique case (frm_q.state)
                S_IDLE: begin
                    if (!rx_i) begin
                        frm_d.state = S_START;
                        frm_d.tcnt  = '0;
                        frm_d.par   = 1'b0;
                        frm_d.perr  = 1'b0;
                    end
                end
                S_START: begin
                    if (nt == CW'(MID) && rx_i) begin
                        frm_d.state = S_IDLE;
                    end else if (at_end) begin
                        frm_d.state = S_DATA;
                        frm_d.bidx  = '0;
                    end
                end
                S_DATA: begin
                    if (at_decide) begin
                        frm_d.shreg = {maj, frm_q.shreg[DATA_BITS-1:1]};
                        frm_d.par   = frm_q.par ^ maj;
                    end
                    if (at_end) begin
                        if (frm_q.bidx == IW'(DATA_BITS - 1)) begin
                            frm_d.state = par_en_i ? S_PAR : S_STOP;
                        end else begin
                            frm_d.bidx = IW'(frm_q.bidx + 1'b1);
                        end
                    end
                end
                S_PAR: begin
                    if (at_decide) frm_d.perr = frm_q.par ^ maj;
                    if (at_end)    frm_d.state = S_STOP;
                end
                S_STOP: begin
                    if (at_decide) begin
                        if (maj) begin
                            frm_d.state     = S_IDLE;
                            frm_d.evt_valid = 1'b1;
                        end else begin
                            frm_d.state = S_HUNT;
                            frm_d.bcnt  = '0;
                        end
                    end
                end
                S_HUNT: begin
                    if (rx_i) begin
                        frm_d.state     = S_IDLE;
                        frm_d.evt_valid = 1'b1;
                        frm_d.evt_ferr  = 1'b1;
                    end else if (frm_q.bcnt == BW'(BRK_TICKS - 1)) begin
                        frm_d.state   = S_LOCK;
                        frm_d.evt_brk = 1'b1;
                    end else begin
                        frm_d.bcnt = BW'(frm_q.bcnt + 1'b1);
                    end
                end
                S_LOCK: frm_d.state = S_LOCK;
                default: frm_d.state = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frm_q <= FRM_RST;
        else        frm_q <= frm_d;
    end

    assign evt_valid_o = frm_q.evt_valid;
    assign evt_data_o  = frm_q.shreg;
    assign evt_perr_o  = frm_q.perr;
    assign evt_ferr_o  = frm_q.evt_ferr;
    assign evt_brk_o   = frm_q.evt_brk;
    assign locked_o    = (frm_q.state == S_LOCK);

    // R6: the lock is left only through a clear
    p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_q.state == S_LOCK && !clr_i) |=> (frm_q.state == S_LOCK));

    // R5: a break event never comes with a character
    p_brk_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frm_q.evt_brk |-> !frm_q.evt_valid);

endmodule

// File: rtl/uart_rxb_fifo.sv
module uart_rxb_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     wr_i,
    input  logic [DW-1:0]            wr_data_i,
    input  logic                     rd_i,
    output logic [DW-1:0]            rd_data_o,
    output logic [$clog2(DEPTH):0]   level_o,
    output logic                     full_o
);

    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wptr;
        logic [AW:0] rptr;
    } ptr_t;

    ptr_t          ptr_d, ptr_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic          wr_ok, rd_ok, empty;

    assign level_o = ptr_q.wptr - ptr_q.rptr;
    assign full_o  = (level_o == (AW+1)'(DEPTH));
    assign empty   = (level_o == '0);
    assign wr_ok   = wr_i && !full_o && !clr_i;
    assign rd_ok   = rd_i && !empty && !clr_i;

    always_comb begin
        ptr_d = ptr_q;
        if (clr_i) begin
            ptr_d = '0;
        end else begin
            if (wr_ok) ptr_d.wptr = ptr_q.wptr + 1'b1;
            if (rd_ok) ptr_d.rptr = ptr_q.rptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[ptr_q.wptr[AW-1:0]] <= wr_data_i;
    end

    assign rd_data_o = mem_q[ptr_q.rptr[AW-1:0]];

    // R9: a write into a full queue leaves the level where it was
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && wr_i && !rd_i && !clr_i) |=> $stable(level_o));

    // R9: the level never exceeds the depth
    p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= (AW+1)'(DEPTH));

endmodule

// File: rtl/uart_rx_break_top.sv
module uart_rx_break_top #(
    parameter int DATA_BITS = 8,
    parameter int OSR       = 16,
    parameter int DEPTH     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_i,
    input  logic                   tick_i,
    input  logic                   rx_en_i,
    input  logic                   par_en_i,
    input  logic                   sleep_i,
    input  logic                   irq_en_i,
    input  logic                   srst_i,
    input  logic                   fifo_en_set_i,
    input  logic                   rd_en_i,
    output logic [DATA_BITS-1:0]   rd_data_o,
    output logic [$clog2(DEPTH):0] level_o,
    output logic                   fifo_en_o,
    output logic                   perr_o,
    output logic                   ferr_o,
    output logic                   brk_o,
    output logic                   ovf_o,
    output logic                   irq_o
);

    localparam int LW = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic rx_m;
        logic rx_s;
        logic fifo_en;
        logic perr;
        logic ferr;
        logic brk;
        logic ovf;
    } ctl_t;

    localparam ctl_t CTL_RST = '{rx_m: 1'b1, rx_s: 1'b1, fifo_en: 1'b0,
                                 perr: 1'b0, ferr: 1'b0, brk: 1'b0, ovf: 1'b0};

    ctl_t                 ctl_d, ctl_q;
    logic                 evt_valid, evt_perr, evt_ferr, evt_brk, locked;
    logic [DATA_BITS-1:0] evt_data;
    logic                 push_req, push, full;
    logic [LW-1:0]        level;

    uart_rxb_frame #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (srst_i),
        .en_i       (rx_en_i),
        .tick_i     (tick_i),
        .rx_i       (ctl_q.rx_s),
        .par_en_i   (par_en_i),
        .evt_valid_o(evt_valid),
        .evt_data_o (evt_data),
        .evt_perr_o (evt_perr),
        .evt_ferr_o (evt_ferr),
        .evt_brk_o  (evt_brk),
        .locked_o   (locked)
    );

    assign push_req = evt_valid && !sleep_i && ctl_q.fifo_en && !srst_i;
    assign push     = push_req && !full;

    uart_rxb_fifo #(.DW(DATA_BITS), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (srst_i),
        .wr_i     (push),
        .wr_data_i(evt_data),
        .rd_i     (rd_en_i),
        .rd_data_o(rd_data_o),
        .level_o  (level),
        .full_o   (full)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rx_m = rx_i;
        ctl_d.rx_s = ctl_q.rx_m;
        if (srst_i) begin
            ctl_d.fifo_en = 1'b0;
            ctl_d.perr    = 1'b0;
            ctl_d.ferr    = 1'b0;
            ctl_d.brk     = 1'b0;
            ctl_d.ovf     = 1'b0;
        end else begin
            if (fifo_en_set_i)                    ctl_d.fifo_en = 1'b1;
            if (evt_valid && !sleep_i && evt_perr) ctl_d.perr = 1'b1;
            if (evt_valid && !sleep_i && evt_ferr) ctl_d.ferr = 1'b1;
            if (evt_brk)                          ctl_d.brk  = 1'b1;
            if (push_req && full)                 ctl_d.ovf  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign level_o   = level;
    assign fifo_en_o = ctl_q.fifo_en;
    assign perr_o    = ctl_q.perr;
    assign ferr_o    = ctl_q.ferr;
    assign brk_o     = ctl_q.brk;
    assign ovf_o     = ctl_q.ovf;
    assign irq_o     = irq_en_i && ((level != '0) || ctl_q.brk);

    // R5: the break event writes nothing into the queue
    p_brk_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_brk |-> !push);

    // R6: while locked, the queue sees no write
    p_lock_no_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.brk && locked) |-> !push);

    // R6: the break flag holds until a soft reset
    p_brk_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.brk && !srst_i) |=> ctl_q.brk);

    // R3: the parity flag holds until a soft reset
    p_perr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.perr && !srst_i) |=> ctl_q.perr);

    // R10: a soft reset empties the queue and clears every flag
    p_srst_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (level == '0 && !ctl_q.perr && !ctl_q.ferr && !ctl_q.brk
                    && !ctl_q.ovf && !ctl_q.fifo_en));

endmodule

// File: tb/sim_uart_rx_break_top.sv
module sim_uart_rx_break_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1, tick = 1'b0, rx_en = 1'b0, par_en = 1'b0, sleep = 1'b0;
    logic       irq_en = 1'b0, srst = 1'b0, fen_set = 1'b0, rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] level;
    logic       fifo_en, perr, ferr, brk, ovf, irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int tdiv = 0;

    // behavioural model
    int m_q[$];
    bit m_fen = 0, m_perr = 0, m_ferr = 0, m_brk = 0, m_ovf = 0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        tick <= (tdiv == 0);
    end

    uart_rx_break_top u0 (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick), .rx_en_i(rx_en),
        .par_en_i(par_en), .sleep_i(sleep), .irq_en_i(irq_en), .srst_i(srst),
        .fifo_en_set_i(fen_set), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .level_o(level), .fifo_en_o(fifo_en), .perr_o(perr), .ferr_o(ferr),
        .brk_o(brk), .ovf_o(ovf), .irq_o(irq)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_irq();
        return (irq_en && (m_q.size() > 0 || m_brk)) ? 1 : 0;
    endfunction

    task automatic check_all(string req);
        chk({req, " level"}, level, m_q.size());
        chk({req, " perr"}, perr, m_perr);
        chk({req, " ferr"}, ferr, m_ferr);
        chk({req, " brk"}, brk, m_brk);
        chk({req, " ovf"}, ovf, m_ovf);
        chk({req, " irq"}, irq, exp_irq());
        chk({req, " fifo_en"}, fifo_en, m_fen);
    endtask

    task automatic drain(string req);
        while (m_q.size() > 0) begin
            chk({req, " data"}, rd_data, m_q[0]);
            void'(m_q.pop_front());
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            @(negedge clk);
        end
        chk({req, " drained"}, level, 0);
    endtask

    task automatic bit_t(logic v);
        rx = v;
        repeat (64) @(negedge clk);
    endtask

    // low_bits = 0: good stop bit; otherwise the line stays low that many bits from the stop slot
    task automatic frame(logic [7:0] d, bit flip, int low_bits);
        bit framing, is_brk;
        bit_t(1'b0);
        for (int i = 0; i < 8; i++) bit_t(d[i]);
        if (par_en) bit_t((^d) ^ flip);
        if (low_bits == 0) bit_t(1'b1);
        else repeat (low_bits) bit_t(1'b0);
        bit_t(1'b1);
        bit_t(1'b1);
        // model
        if (!rx_en || m_brk) return;
        is_brk  = (low_bits > 0) && (low_bits * 16 - 9 >= 154);
        framing = (low_bits > 0) && !is_brk;
        if (is_brk) begin
            m_brk = 1;
            return;
        end
        if (sleep) return;
        if (par_en && flip) m_perr = 1;
        if (framing) m_ferr = 1;
        if (!m_fen) return;
        if (m_q.size() == 16) m_ovf = 1;
        else m_q.push_back(d);
    endtask

    task automatic soft_reset();
        srst = 1'b1;
        repeat (2) @(negedge clk);
        srst = 1'b0;
        @(negedge clk);
        m_q.delete();
        m_fen = 0; m_perr = 0; m_ferr = 0; m_brk = 0; m_ovf = 0;
    endtask

    task automatic enable_fifo();
        fen_set = 1'b1;
        @(negedge clk);
        fen_set = 1'b0;
        @(negedge clk);
        m_fen = 1;
    endtask

    initial begin
        repeat (180000) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R1 reset");

        rx_en = 1'b1; irq_en = 1'b1;
        enable_fifo();
        check_all("R11 enable");
        frame(8'hA5, 0, 0);
        frame(8'h3C, 0, 0);
        check_all("R2 two frames");
        drain("R2");

        par_en = 1'b1;
        frame(8'h5A, 0, 0);
        check_all("R3 good parity");
        frame(8'h81, 1, 0);
        check_all("R3 bad parity");
        drain("R3");
        par_en = 1'b0;

        frame(8'h77, 0, 3);
        check_all("R4 short low stop");
        frame(8'h12, 0, 0);
        check_all("R4 flow after ferr");
        drain("R4");

        soft_reset();
        check_all("R10 soft reset");
        frame(8'h44, 0, 0);
        check_all("R11 queue disabled");
        enable_fifo();

        irq_en = 1'b0;
        frame(8'h99, 0, 0);
        @(negedge clk);
        check_all("R7 irq masked");
        irq_en = 1'b1;
        @(negedge clk);
        check_all("R7 irq on data");
        drain("R7");

        for (int i = 0; i < 17; i++) frame(8'(i * 13 + 1), 0, 0);
        check_all("R9 overflow");
        drain("R9");
        soft_reset();
        enable_fifo();

        frame(8'h00, 0, 9);
        check_all("R4 boundary below break");
        drain("R4 boundary");
        soft_reset();
        enable_fifo();

        sleep = 1'b1;
        frame(8'h33, 0, 0);
        check_all("R8 sleep discards");
        frame(8'h00, 0, 11);
        check_all("R8 break in sleep");
        sleep = 1'b0;
        irq_en = 1'b0;
        @(negedge clk);
        check_all("R7 break masked");
        irq_en = 1'b1;
        @(negedge clk);
        check_all("R7 break irq");
        frame(8'h21, 0, 0);
        check_all("R6 locked after break");
        soft_reset();
        enable_fifo();

        frame(8'h11, 0, 0);
        frame(8'h00, 0, 11);
        check_all("R5 break no write");
        frame(8'h22, 0, 0);
        check_all("R6 lock holds");
        drain("R6");
        soft_reset();
        check_all("R10 clears break");
        enable_fifo();
        frame(8'h6B, 0, 0);
        check_all("R10 receive after reset");
        drain("R10");

        rx_en = 1'b0;
        frame(8'h55, 0, 0);
        check_all("R12 disabled");
        rx_en = 1'b1;
        frame(8'h66, 0, 0);
        check_all("R12 enabled");
        drain("R12");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule